// File: doc/BRIEF.md
# Command Channel Register File with Completion Interrupt

This block is the software-facing register set of one command channel. Software uses it to place the 64-bit base of an in-memory command list and to post commands by marking slots as pending. It then watches a status word for completion or failure. A command engine outside the block reads the base address, the polling enable and the pending vector. It reports progress back through strobes: a completion pulse, an error pulse carrying the failing slot and buffer numbers, and a per-slot clear of the pending bits.

Each register has its own access rule. A write to the status word wipes it, whatever the data. A write to the pending vector only adds bits, and the engine removes them. Writing zero to the control word resets the channel's software state. The interrupt line combines the status and enable bits and is registered once.

Register accesses use a plain single-cycle strobe. A write takes effect at the clock edge where `reg_en` and `reg_we` are both high. Reads are combinational from `reg_addr`. The block has no data stream, so there is no valid/ready handshake and no back-pressure: every access completes in the cycle it is presented. Each channel decodes a 4 KB window. Registers sit at byte offsets 0x000 (base low), 0x004 (base high), 0x008 (status), 0x00C (interrupt enable), 0x010 (control) and 0x014 (pending). Every other offset in the window is empty. The window itself lies in a segment aligned to 32 KB.

Top module: `cmdq_chan_regs`

## Requirements
- R1: After reset every register reads zero, and `list_base`, `poll_en`, `pend_vec` and `irq` are zero.
- R2: Offsets 0x000 and 0x004 hold the low and high words of `list_base`. Bits 3:0 of the low word always read zero and appear as zero on `list_base`, which keeps the base 16-byte aligned.
- R3: Any write to status (0x008) clears all of its bits, whatever the write data.
- R4: Status layout: bit 0 is done, bit 30 is error, bits 28:24 hold the failing slot and bits 23:8 the failing buffer. All other bits read zero. A pulse on `eng_done` sets bit 0. A pulse on `eng_err` sets bit 30 and captures `eng_err_slot` and `eng_err_buf`, but only if bit 30 was clear; while bit 30 stays set, the fields of the first error are kept.
- R5: If an engine strobe arrives in the same cycle as a status write, the bit set by the strobe is present after that edge.
- R6: The interrupt enable (0x00C) stores only bit 0 (enable on done) and bit 30 (enable on error). Its other bits read zero.
- R7: `irq` equals (status bit 0 AND enable bit 0) OR (status bit 30 AND enable bit 30), delayed by exactly one clock.
- R8: A nonzero write to control (0x010) sets `poll_en`, and control then reads 1. A zero write clears pending, status, interrupt enable and control in that cycle, and leaves the base words untouched.
- R9: A write to pending (0x014) ORs the data into the vector. A high bit of `eng_clr` clears the matching pending bit.
- R10: When a software write sets a pending bit in the same cycle that `eng_clr` clears it, the bit ends up set.
- R11: Offsets other than the six listed above, including offsets that are not word aligned, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_en | input | 1 | Access strobe |
| reg_we | input | 1 | Write qualifier for the access |
| reg_addr | input | 12 | Byte offset within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_done | input | 1 | Engine pulse: a command completed |
| eng_err | input | 1 | Engine pulse: a command failed |
| eng_err_slot | input | 5 | Slot number of the failed command |
| eng_err_buf | input | 16 | Buffer number inside the failed command |
| eng_clr | input | NUM_SLOTS | Per-slot clear of pending bits |
| list_base | output | 64 | Command list base address |
| poll_en | output | 1 | List polling enabled |
| pend_vec | output | NUM_SLOTS | Pending command vector |
| irq | output | 1 | Channel interrupt |

## Verification
The properties assume that an access is presented only while `reg_en` is high, and that the engine strobes are single-cycle pulses with their slot and buffer values valid alongside them. Some properties relate a write to the register state after it. Those properties exclude cycles where an engine strobe hits the same register, because those collisions have their own rules (R5, R10). The stimulus drives every input at the falling edge and holds it for exactly one cycle. It raises the engine strobes together with a write only in the directed cases that target those collisions.

// File: rtl/cmdq_regs_pkg.sv
package cmdq_regs_pkg;
  localparam int WIN_BYTES = 4096;
  localparam int ADDR_W    = $clog2(WIN_BYTES);

  localparam logic [ADDR_W-1:0] OFF_BASE_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_BASE_HI = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_PEND    = 12'h014;

  localparam int ST_DONE_BIT = 0;
  localparam int ST_ERR_BIT  = 30;
  localparam int ST_SLOT_LSB = 24;
  localparam int ST_SLOT_W   = 5;
  localparam int ST_BUF_LSB  = 8;
  localparam int ST_BUF_W    = 16;
  localparam int BASE_ALIGN  = 4;

  typedef struct packed {
    logic                 err;
    logic [ST_SLOT_W-1:0] slot;
    logic [ST_BUF_W-1:0]  buff;
    logic                 done;
  } status_t;
endpackage

// File: rtl/cmdq_status_reg.sv
module cmdq_status_reg
  import cmdq_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 st_wr,
  input  logic                 ie_wr,
  input  logic [31:0]          wdata,
  input  logic                 ev_done,
  input  logic                 ev_err,
  input  logic [ST_SLOT_W-1:0] ev_slot,
  input  logic [ST_BUF_W-1:0]  ev_buf,
  output logic [31:0]          status_word,
  output logic [31:0]          ie_word
);
  status_t st_q, st_d;
  logic    ie_done_q, ie_err_q;

  always_comb begin
    st_d = st_q;
    if (st_wr) st_d = '0;
    if (ev_done) st_d.done = 1'b1;
    if (ev_err && !st_d.err) begin
      st_d.err  = 1'b1;
      st_d.slot = ev_slot;
      st_d.buff = ev_buf;
    end
    if (soft_rst) st_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      ie_done_q <= 1'b0;
      ie_err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (soft_rst) begin
        ie_done_q <= 1'b0;
        ie_err_q  <= 1'b0;
      end else if (ie_wr) begin
        ie_done_q <= wdata[ST_DONE_BIT];
        ie_err_q  <= wdata[ST_ERR_BIT];
      end
    end
  end

  always_comb begin
    status_word = '0;
    status_word[ST_DONE_BIT] = st_q.done;
    status_word[ST_ERR_BIT]  = st_q.err;
    status_word[ST_SLOT_LSB +: ST_SLOT_W] = st_q.slot;
    status_word[ST_BUF_LSB +: ST_BUF_W]   = st_q.buff;
    ie_word = '0;
    ie_word[ST_DONE_BIT] = ie_done_q;
    ie_word[ST_ERR_BIT]  = ie_err_q;
  end
endmodule

// File: rtl/cmdq_pend_vec.sv
module cmdq_pend_vec #(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 sw_wr,
  input  logic [NUM_SLOTS-1:0] sw_set,
  input  logic [NUM_SLOTS-1:0] hw_clr,
  output logic [NUM_SLOTS-1:0] pend
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bit_q <= 1'b0;
      else if (soft_rst)           bit_q <= 1'b0;
      else if (sw_wr && sw_set[i]) bit_q <= 1'b1;
      else if (hw_clr[i])          bit_q <= 1'b0;
    end
    assign pend[i] = bit_q;
  end
endmodule

// File: rtl/cmdq_chan_regs.sv
module cmdq_chan_regs
  import cmdq_regs_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 eng_done,
  input  logic                 eng_err,
  input  logic [ST_SLOT_W-1:0] eng_err_slot,
  input  logic [ST_BUF_W-1:0]  eng_err_buf,
  input  logic [NUM_SLOTS-1:0] eng_clr,
  output logic [63:0]          list_base,
  output logic                 poll_en,
  output logic [NUM_SLOTS-1:0] pend_vec,
  output logic                 irq
);
  logic        wr;
  logic        wr_lo, wr_hi, wr_st, wr_ie, wr_ctrl, wr_pend, soft_rst;
  logic [31:BASE_ALIGN] base_lo_q;
  logic [31:0] base_hi_q;
  logic        ctrl_q, irq_q;
  logic [31:0] status_word, ie_word;

  assign wr       = reg_en && reg_we;
  assign wr_lo    = wr && (reg_addr == OFF_BASE_LO);
  assign wr_hi    = wr && (reg_addr == OFF_BASE_HI);
  assign wr_st    = wr && (reg_addr == OFF_STATUS);
  assign wr_ie    = wr && (reg_addr == OFF_IRQ_EN);
  assign wr_ctrl  = wr && (reg_addr == OFF_CTRL);
  assign wr_pend  = wr && (reg_addr == OFF_PEND);
  assign soft_rst = wr_ctrl && (reg_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      ctrl_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_lo)   base_lo_q <= reg_wdata[31:BASE_ALIGN];
      if (wr_hi)   base_hi_q <= reg_wdata;
      if (wr_ctrl) ctrl_q    <= |reg_wdata;
      irq_q <= (status_word[ST_DONE_BIT] && ie_word[ST_DONE_BIT]) ||
               (status_word[ST_ERR_BIT]  && ie_word[ST_ERR_BIT]);
    end
  end

  cmdq_status_reg u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .st_wr       (wr_st),
    .ie_wr       (wr_ie),
    .wdata       (reg_wdata),
    .ev_done     (eng_done),
    .ev_err      (eng_err),
    .ev_slot     (eng_err_slot),
    .ev_buf      (eng_err_buf),
    .status_word (status_word),
    .ie_word     (ie_word)
  );

  cmdq_pend_vec #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .sw_wr    (wr_pend),
    .sw_set   (reg_wdata[NUM_SLOTS-1:0]),
    .hw_clr   (eng_clr),
    .pend     (pend_vec)
  );

  always_comb begin
    unique case (reg_addr)
      OFF_BASE_LO: reg_rdata = {base_lo_q, {BASE_ALIGN{1'b0}}};
      OFF_BASE_HI: reg_rdata = base_hi_q;
      OFF_STATUS:  reg_rdata = status_word;
      OFF_IRQ_EN:  reg_rdata = ie_word;
      OFF_CTRL:    reg_rdata = {31'd0, ctrl_q};
      OFF_PEND:    reg_rdata = 32'(pend_vec);
      default:     reg_rdata = '0;
    endcase
  end

  assign list_base = {base_hi_q, base_lo_q, {BASE_ALIGN{1'b0}}};
  assign poll_en   = ctrl_q;
  assign irq       = irq_q;
endmodule

// File: rtl/cmdq_chan_regs_chk.sv
module cmdq_chan_regs_chk
  import cmdq_regs_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_en,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [31:0]          reg_wdata,
  input logic                 eng_done,
  input logic                 eng_err,
  input logic [NUM_SLOTS-1:0] eng_clr,
  input logic                 poll_en,
  input logic [NUM_SLOTS-1:0] pend_vec,
  input logic                 irq,
  input logic [31:0]          status_word,
  input logic [31:0]          ie_word
);
  logic c_wr, c_st_wr, c_pend_wr, c_soft, c_irq_cond;
  logic [NUM_SLOTS-1:0] c_set;
  assign c_wr       = reg_en && reg_we;
  assign c_st_wr    = c_wr && (reg_addr == OFF_STATUS);
  assign c_pend_wr  = c_wr && (reg_addr == OFF_PEND);
  assign c_soft     = c_wr && (reg_addr == OFF_CTRL) && (reg_wdata == '0);
  assign c_set      = reg_wdata[NUM_SLOTS-1:0];
  assign c_irq_cond = (status_word[ST_DONE_BIT] && ie_word[ST_DONE_BIT]) ||
                      (status_word[ST_ERR_BIT]  && ie_word[ST_ERR_BIT]);

  assert_status_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_st_wr && !eng_done && !eng_err) |=> (status_word == '0));

  assert_done_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !c_soft) |=> status_word[ST_DONE_BIT]);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_irq_cond |=> irq);

  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !c_irq_cond |=> !irq);

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_soft |=> (pend_vec == '0 && !poll_en && status_word == '0 && ie_word == '0));

  assert_hw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !c_pend_wr |=> ((pend_vec & $past(eng_clr)) == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_pend_wr |=> ((pend_vec & $past(c_set)) == $past(c_set)));
endmodule

bind cmdq_chan_regs cmdq_chan_regs_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_en      (reg_en),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .eng_done    (eng_done),
  .eng_err     (eng_err),
  .eng_clr     (eng_clr),
  .poll_en     (poll_en),
  .pend_vec    (pend_vec),
  .irq         (irq),
  .status_word (status_word),
  .ie_word     (ie_word)
);

// File: tb/cmdq_chan_regs_bench.sv
module cmdq_chan_regs_bench;
  localparam int NS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic [4:0] eng_err_slot = '0;
  logic [15:0] eng_err_buf = '0;
  logic [NS-1:0] eng_clr = '0, pend_vec;
  logic [63:0] list_base;
  logic poll_en, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmdq_chan_regs #(.NUM_SLOTS(NS)) u_cmdq_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_done(eng_done), .eng_err(eng_err), .eng_err_slot(eng_err_slot),
    .eng_err_buf(eng_err_buf), .eng_clr(eng_clr), .list_base(list_base),
    .poll_en(poll_en), .pend_vec(pend_vec), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd2,  12'h000, 32'h1234_567F},
    '{1'b0, 4'd2,  12'h000, 32'h1234_5670},  // R2 low nibble forced to zero
    '{1'b1, 4'd2,  12'h004, 32'hDEAD_BEEF},
    '{1'b0, 4'd2,  12'h004, 32'hDEAD_BEEF},
    '{1'b1, 4'd6,  12'h00C, 32'hFFFF_FFFF},
    '{1'b0, 4'd6,  12'h00C, 32'h4000_0001},  // R6 only bits 30 and 0
    '{1'b1, 4'd9,  12'h014, 32'h0000_00F0},
    '{1'b1, 4'd9,  12'h014, 32'h0000_0003},
    '{1'b0, 4'd9,  12'h014, 32'h0000_00F3},  // R9 OR accumulation
    '{1'b1, 4'd8,  12'h010, 32'h0000_0005},
    '{1'b0, 4'd8,  12'h010, 32'h0000_0001},  // R8 nonzero enables
    '{1'b1, 4'd11, 12'h020, 32'hFFFF_FFFF},
    '{1'b0, 4'd11, 12'h020, 32'h0000_0000},  // R11 unmapped reads zero
    '{1'b1, 4'd11, 12'h002, 32'hFFFF_FFFF},
    '{1'b0, 4'd11, 12'h002, 32'h0000_0000},  // R11 misaligned reads zero
    '{1'b0, 4'd11, 12'h014, 32'h0000_00F3},
    '{1'b0, 4'd11, 12'h00C, 32'h4000_0001}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [11:0] a, input logic [31:0] d, input logic dn,
                       input logic er, input logic [4:0] sl, input logic [15:0] bf,
                       input logic [NS-1:0] cl, input logic do_wr);
    @(negedge clk);
    reg_en = do_wr; reg_we = do_wr; reg_addr = a; reg_wdata = d;
    eng_done = dn; eng_err = er; eng_err_slot = sl; eng_err_buf = bf; eng_clr = cl;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; eng_done = 1'b0; eng_err = 1'b0; eng_clr = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_ev(a, d, 1'b0, 1'b0, '0, '0, '0, 1'b1);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 list_base", list_base, 64'd0);
    check("R1 poll_en", {63'd0, poll_en}, 64'd0);
    check("R1 pend_vec", {32'd0, pend_vec}, 64'd0);
    check("R1 irq", {63'd0, irq}, 64'd0);
    for (int a = 0; a < 6; a++) begin
      rd(12'(a * 4), v);
      check("R1 register", {32'd0, v}, 64'd0);
    end

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        n_chk++;
        if (v !== VEC[i].data) begin
          n_bad++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i].req, i, v, VEC[i].data);
        end
      end
    end
    check("R2 list_base", list_base, 64'hDEAD_BEEF_1234_5670);
    check("R8 poll_en", {63'd0, poll_en}, 64'd1);
    check("R9 pend_vec port", {32'd0, pend_vec}, 64'h0F3);

    // R4 / R7: done pulse then irq one cycle later
    wr_ev(12'h000, 0, 1'b1, 1'b0, '0, '0, '0, 1'b0);
    rd(12'h008, v);
    check("R4 done bit", {32'd0, v}, 64'h1);
    check("R7 irq not yet", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R7 irq after one cycle", {63'd0, irq}, 64'd1);
    wr_ev(12'h000, 0, 1'b0, 1'b1, 5'd5, 16'h1234, '0, 1'b0);
    rd(12'h008, v);
    check("R4 error capture", {32'd0, v}, 64'h4512_3401);
    wr_ev(12'h000, 0, 1'b0, 1'b1, 5'd7, 16'hAAAA, '0, 1'b0);
    rd(12'h008, v);
    check("R4 first error held", {32'd0, v}, 64'h4512_3401);

    // R3 clear regardless of data
    wr(12'h008, 32'h0000_0000);
    rd(12'h008, v);
    check("R3 status cleared", {32'd0, v}, 64'd0);
    @(negedge clk);
    check("R7 irq falls", {63'd0, irq}, 64'd0);
    wr_ev(12'h000, 0, 1'b1, 1'b0, '0, '0, '0, 1'b0);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, v);
    check("R3 cleared with ones data", {32'd0, v}, 64'd0);

    // R5 event same cycle as status write
    wr_ev(12'h008, 32'hFFFF_FFFF, 1'b1, 1'b0, '0, '0, '0, 1'b1);
    rd(12'h008, v);
    check("R5 done survives clear", {32'd0, v}, 64'h1);

    // R10 set and clear collide: bit0 set+clr, bit1 clr only
    wr_ev(12'h014, 32'h1, 1'b0, 1'b0, '0, '0, 32'h3, 1'b1);
    rd(12'h014, v);
    check("R10 set wins", {32'd0, v}, 64'hF1);
    wr_ev(12'h000, 0, 1'b0, 1'b0, '0, '0, 32'hF0, 1'b0);
    rd(12'h014, v);
    check("R9 hw clear", {32'd0, v}, 64'h01);

    // R11 write to unmapped offset alters nothing
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h014, v);
    check("R11 pend untouched", {32'd0, v}, 64'h01);
    rd(12'h008, v);
    check("R11 status untouched", {32'd0, v}, 64'h1);

    // R8 soft reset via zero write
    wr(12'h010, 32'h0);
    rd(12'h014, v);
    check("R8 pend cleared", {32'd0, v}, 64'd0);
    rd(12'h008, v);
    check("R8 status cleared", {32'd0, v}, 64'd0);
    rd(12'h00C, v);
    check("R8 enable cleared", {32'd0, v}, 64'd0);
    rd(12'h010, v);
    check("R8 control cleared", {32'd0, v}, 64'd0);
    check("R8 poll_en low", {63'd0, poll_en}, 64'd0);
    check("R8 base kept", list_base, 64'hDEAD_BEEF_1234_5670);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule